// File: doc/BRIEF.md
# Configurable Pad Cell Bank

This block is a bank of sixteen pad cells placed between sixteen bidirectional pads and the internal logic fabric. Each cell carries its own 5-bit configuration word, which gives it one of five personalities at run time. It can be a plain combinational input, an input sampled by an edge-triggered flop, or an input held by a level-sensitive latch. It can also be a constant output driver, or a bidirectional pin whose driver follows a bank-wide output enable. Each driven value can be inverted per cell. The value that goes back into the fabric is never inverted.

The pad itself is modelled as three separate signals: the level seen on the pad (`pad_i`), the value to drive (`pad_o`) and the driver enable (`pad_en`). The pad ring above the block combines these into a real three-state buffer. Two I/O clock lines serve the capture paths. Each cell picks one of them for its flop and its latch. An asynchronous active-high reset clears every stored input bit.

Top module: `io_cell_bank`

## Requirements
- R1: Configuration word of cell i is `cell_cfg[5i+4:5i]`: bits [2:0] mode, bit 3 invert, bit 4 clock select. Mode 000 (combinational input) never drives the pad, and `core_in[i]` equals `pad_i[i]` at all times.
- R2: Mode 001 (registered input) presents on `core_in[i]` the value of `pad_i[i]` captured at the last rising edge of the selected I/O clock, and holds it between edges.
- R3: Mode 010 (latched input) passes `pad_i[i]` through while the selected I/O clock is high and holds the last value while it is low.
- R4: Mode 011 (output) asserts `pad_en[i]` whatever the value of `bank_oe`.
- R5: Mode 100 (bidirectional) asserts `pad_en[i]` exactly when `bank_oe` is high, and `core_in[i]` follows the pad, so a driving cell reads back its own driven level.
- R6: With invert = 1 a driven cell outputs `~core_out[i]`. With invert = 0 it outputs `core_out[i]`. The value returned on `core_in` is never inverted.
- R7: Mode codes 101, 110 and 111 do not drive the pad and read `pad_i[i]` combinationally.
- R8: `pad_o[i]` is 0 whenever `pad_en[i]` is 0.
- R9: Raising `rst` clears every capture flop and latch to 0 at once, without waiting for a clock edge, and keeps them at 0 while it stays high.
- R10: Clock select 0 uses `ioclk[0]` and clock select 1 uses `ioclk[1]`. Edges or high levels on the other line have no effect on the cell's captured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Asynchronous active-high reset of capture state |
| ioclk | input | 2 | The two I/O clock lines |
| bank_oe | input | 1 | Output enable shared by all cells |
| cell_cfg | input | 80 | Sixteen 5-bit cell configuration words |
| core_out | input | 16 | Values from the fabric to be driven |
| core_in | output | 16 | Values returned to the fabric |
| pad_i | input | 16 | Level present on each pad |
| pad_o | output | 16 | Value to drive onto each pad |
| pad_en | output | 16 | Driver enable of each pad |

## Verification
The bench goes after the difference between output and bidirectional modes when `bank_oe` is low. A design that gated the output mode with the enable would release pads that must stay driven. Inversion is checked in both directions of travel, which catches a design that also inverts the read-back path. Capture is checked just before and just after a clock edge, and a latch is checked across its closing level, so an off-by-one-edge flop or a latch transparent on the wrong level shows a stale or early value. The clock select is tested with the unselected line running, and reset is raised between edges to expose a synchronous clear. The undefined mode codes are checked to confirm that they leave the pad undriven.

// File: rtl/iobank_pkg.sv
package iobank_pkg;

    localparam int NUM_CLK = 2;
    localparam int SEL_W   = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1;
    localparam int CFG_W   = 3 + 1 + SEL_W;

    localparam logic [2:0] MODE_COMB  = 3'b000;
    localparam logic [2:0] MODE_REG   = 3'b001;
    localparam logic [2:0] MODE_LATCH = 3'b010;
    localparam logic [2:0] MODE_OUT   = 3'b011;
    localparam logic [2:0] MODE_BIDIR = 3'b100;

    typedef struct packed {
        logic [SEL_W-1:0] clk_sel;
        logic             invert;
        logic [2:0]       mode;
    } cell_cfg_t;

    typedef enum logic [1:0] {
        SRC_PAD   = 2'd0,
        SRC_REG   = 2'd1,
        SRC_LATCH = 2'd2
    } in_src_e;

    typedef struct packed {
        logic    drv_fixed;
        logic    drv_gated;
        in_src_e src;
    } cell_ctl_t;

    function automatic cell_ctl_t decode_mode(input logic [2:0] m);
        cell_ctl_t c;
        c.drv_fixed = 1'b0;
        c.drv_gated = 1'b0;
        c.src       = SRC_PAD;
        case (m)
            MODE_REG:   c.src       = SRC_REG;
            MODE_LATCH: c.src       = SRC_LATCH;
            MODE_OUT:   c.drv_fixed = 1'b1;
            MODE_BIDIR: c.drv_gated = 1'b1;
            default:    c.src       = SRC_PAD;
        endcase
        return c;
    endfunction

    function automatic logic apply_polarity(input logic v, input logic inv);
        return v ^ inv;
    endfunction

endpackage

// File: rtl/iocell_capture.sv
module iocell_capture
    import iobank_pkg::*;
#(
    parameter int NCLK = NUM_CLK
) (
    input  logic            rst,
    input  logic [NCLK-1:0] clk,
    input  logic            d,
    output logic [NCLK-1:0] q_edge,
    output logic [NCLK-1:0] q_level
);

    // One flop and one latch per clock line; the cell picks afterwards.
    for (genvar k = 0; k < NCLK; k++) begin : g_clk
        logic edge_q;
        logic lvl_q;

        always_ff @(posedge clk[k] or posedge rst) begin
            if (rst) edge_q <= 1'b0;
            else     edge_q <= d;
        end

        always_latch begin
            if (rst)         lvl_q <= 1'b0;
            else if (clk[k]) lvl_q <= d;
        end

        assign q_edge[k]  = edge_q;
        assign q_level[k] = lvl_q;

        // R9: stored state is zero whenever reset is seen at a clock edge
        p_reset_clear_r9: assert property (@(posedge clk[k])
            rst |-> (q_edge[k] == 1'b0 && q_level[k] == 1'b0))
            else $error("R9 capture state not cleared by reset");
    end

endmodule

// File: rtl/iocell_drive.sv
module iocell_drive
    import iobank_pkg::*;
(
    input  cell_ctl_t ctl,
    input  logic      invert,
    input  logic      oe,
    input  logic      d,
    output logic      pad_o,
    output logic      pad_en
);

    assign pad_en = ctl.drv_fixed | (ctl.drv_gated & oe);
    assign pad_o  = pad_en ? apply_polarity(d, invert) : 1'b0;

endmodule

// File: rtl/iocell.sv
module iocell
    import iobank_pkg::*;
(
    input  logic                rst,
    input  logic [NUM_CLK-1:0]  clk,
    input  logic                oe,
    input  cell_cfg_t           cfg,
    input  logic                core_out,
    output logic                core_in,
    input  logic                pad_i,
    output logic                pad_o,
    output logic                pad_en
);

    cell_ctl_t          ctl;
    logic [NUM_CLK-1:0] q_edge;
    logic [NUM_CLK-1:0] q_level;

    assign ctl = decode_mode(cfg.mode);

    iocell_capture #(.NCLK(NUM_CLK)) u_cap (
        .rst     (rst),
        .clk     (clk),
        .d       (pad_i),
        .q_edge  (q_edge),
        .q_level (q_level)
    );

    iocell_drive u_drv (
        .ctl    (ctl),
        .invert (cfg.invert),
        .oe     (oe),
        .d      (core_out),
        .pad_o  (pad_o),
        .pad_en (pad_en)
    );

    always_comb begin
        case (ctl.src)
            SRC_REG:   core_in = q_edge[cfg.clk_sel];
            SRC_LATCH: core_in = q_level[cfg.clk_sel];
            default:   core_in = pad_i;
        endcase
    end

endmodule

// File: rtl/io_cell_bank.sv
module io_cell_bank
    import iobank_pkg::*;
#(
    parameter int NCELL = 16
) (
    input  logic                   rst,
    input  logic [NUM_CLK-1:0]     ioclk,
    input  logic                   bank_oe,
    input  logic [NCELL*CFG_W-1:0] cell_cfg,
    input  logic [NCELL-1:0]       core_out,
    output logic [NCELL-1:0]       core_in,
    input  logic [NCELL-1:0]       pad_i,
    output logic [NCELL-1:0]       pad_o,
    output logic [NCELL-1:0]       pad_en
);

    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        cell_cfg_t c;
        assign c = cell_cfg[i*CFG_W +: CFG_W];

        iocell u_cell (
            .rst      (rst),
            .clk      (ioclk),
            .oe       (bank_oe),
            .cfg      (c),
            .core_out (core_out[i]),
            .core_in  (core_in[i]),
            .pad_i    (pad_i[i]),
            .pad_o    (pad_o[i]),
            .pad_en   (pad_en[i])
        );

        // R4: output mode drives regardless of the shared enable
        p_out_drives_r4: assert property (@(posedge ioclk[0]) disable iff (rst)
            (c.mode == MODE_OUT) |-> pad_en[i])
            else $error("R4 output cell not driving");

        // R5: bidirectional driver tracks the shared enable
        p_bidir_oe_r5: assert property (@(posedge ioclk[0]) disable iff (rst)
            (c.mode == MODE_BIDIR) |-> (pad_en[i] == bank_oe))
            else $error("R5 bidir enable mismatch");

        // R1 and R7: non-driving modes keep the pad released
        p_input_quiet_r1: assert property (@(posedge ioclk[0]) disable iff (rst)
            (c.mode != MODE_OUT && c.mode != MODE_BIDIR) |-> !pad_en[i])
            else $error("R1 input cell driving pad");

        // R8: released pad carries a zero data value
        p_idle_low_r8: assert property (@(posedge ioclk[0]) disable iff (rst)
            !pad_en[i] |-> !pad_o[i])
            else $error("R8 pad_o not zero while released");

        // R7: uncaptured modes return the pad level
        p_pad_read_r7: assert property (@(posedge ioclk[0]) disable iff (rst)
            (c.mode != MODE_REG && c.mode != MODE_LATCH) |-> (core_in[i] == pad_i[i]))
            else $error("R7 fabric value differs from pad");
    end

endmodule

// File: tb/sim_io_cell_bank.sv
module sim_io_cell_bank;
    import iobank_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N = 16;
    localparam int NROW = 10;

    // row: mode[84:82] inv[81] oe[80] core_out[79:64] ext[63:48]
    //      exp_en[47:32] exp_o[31:16] exp_in[15:0]
    localparam logic [84:0] VEC [NROW] = '{
        {3'b000, 1'b0, 1'b1, 16'hFFFF, 16'hA5C3, 16'h0000, 16'h0000, 16'hA5C3},
        {3'b011, 1'b0, 1'b0, 16'h1234, 16'hFFFF, 16'hFFFF, 16'h1234, 16'h1234},
        {3'b011, 1'b1, 1'b0, 16'h1234, 16'h0000, 16'hFFFF, 16'hEDCB, 16'hEDCB},
        {3'b100, 1'b0, 1'b1, 16'h0F0F, 16'hF0F0, 16'hFFFF, 16'h0F0F, 16'h0F0F},
        {3'b100, 1'b0, 1'b0, 16'h0F0F, 16'hF0F0, 16'h0000, 16'h0000, 16'hF0F0},
        {3'b100, 1'b1, 1'b1, 16'h00FF, 16'h0000, 16'hFFFF, 16'hFF00, 16'hFF00},
        {3'b101, 1'b1, 1'b1, 16'hFFFF, 16'h3C3C, 16'h0000, 16'h0000, 16'h3C3C},
        {3'b111, 1'b0, 1'b1, 16'hFFFF, 16'h8001, 16'h0000, 16'h0000, 16'h8001},
        {3'b100, 1'b1, 1'b0, 16'h00FF, 16'h5555, 16'h0000, 16'h0000, 16'h5555},
        {3'b000, 1'b1, 1'b1, 16'h0000, 16'h6666, 16'h0000, 16'h0000, 16'h6666}
    };

    logic          rst;
    logic          clk0;
    logic          clk1;
    logic          bank_oe;
    logic [N*5-1:0] cell_cfg;
    logic [N-1:0]  core_out;
    logic [N-1:0]  core_in;
    logic [N-1:0]  ext;
    logic [N-1:0]  pad_i;
    logic [N-1:0]  pad_o;
    logic [N-1:0]  pad_en;

    int total = 0;
    int bad   = 0;

    // pad model: a driving cell wins, otherwise the outside world sets the level
    assign pad_i = (pad_en & pad_o) | (~pad_en & ext);

    io_cell_bank #(.NCELL(N)) u0 (
        .rst      (rst),
        .ioclk    ({clk1, clk0}),
        .bank_oe  (bank_oe),
        .cell_cfg (cell_cfg),
        .core_out (core_out),
        .core_in  (core_in),
        .pad_i    (pad_i),
        .pad_o    (pad_o),
        .pad_en   (pad_en)
    );

    initial clk0 = 1'b0;
    always #(CLK_PERIOD/2) clk0 = ~clk0;

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_all(input logic sel, input logic inv, input logic [2:0] mode);
        cell_cfg = {N{sel, inv, mode}};
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        total++;
        bad++;
        $display("FAIL watchdog all requirements actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [84:0] v;
        logic [N*5-1:0] mix;
        rst = 1'b0; clk1 = 1'b0; bank_oe = 1'b0;
        core_out = '0; ext = '0; cell_cfg = '0;
        #1 rst = 1'b1;

        // R9: reset holds registered and latched state at zero
        set_all(1'b0, 1'b0, MODE_REG);
        ext = 16'hFFFF;
        repeat (2) @(posedge clk0);
        #1 chk("R9 reg cleared during reset", core_in, 16'h0000);
        set_all(1'b0, 1'b0, MODE_LATCH);
        #1 chk("R9 latch cleared during reset", core_in, 16'h0000);
        set_all(1'b0, 1'b0, MODE_REG);
        ext = 16'hA5A5;

        // R2: capture on rising edge only
        @(negedge clk0);
        rst = 1'b0;
        #1 chk("R2 no capture before edge", core_in, 16'h0000);
        @(posedge clk0);
        #1 chk("R2 capture at edge", core_in, 16'hA5A5);
        @(negedge clk0);
        #1 ext = 16'h5A5A;
        #1 chk("R2 hold between edges", core_in, 16'hA5A5);
        @(posedge clk0);
        #1 chk("R2 second capture", core_in, 16'h5A5A);

        // R3: latch on ioclk[0]
        set_all(1'b0, 1'b0, MODE_LATCH);
        ext = 16'h3C3C;
        #1 chk("R3 transparent while high", core_in, 16'h3C3C);
        @(negedge clk0);
        #1 ext = 16'h0000;
        #1 chk("R3 hold while low", core_in, 16'h3C3C);

        // R1 R4 R5 R6 R7 R8: combinational behaviour table
        for (int k = 0; k < NROW; k++) begin
            v = VEC[k];
            @(negedge clk0);
            #1;
            set_all(1'b0, v[81], v[84:82]);
            bank_oe  = v[80];
            core_out = v[79:64];
            ext      = v[63:48];
            #1;
            chk($sformatf("R1 R4 R5 R7 enable row %0d", k), pad_en, v[47:32]);
            chk($sformatf("R6 R8 pad value row %0d", k), pad_o, v[31:16]);
            chk($sformatf("R5 R6 R7 fabric value row %0d", k), core_in, v[15:0]);
        end

        // R10: registered cell bound to ioclk[1] ignores ioclk[0]
        @(negedge clk0);
        #1;
        set_all(1'b1, 1'b0, MODE_REG);
        ext = 16'hFFFF;
        #1 chk("R10 before selected edge", core_in, 16'h0000);
        repeat (2) @(posedge clk0);
        #1 chk("R10 unselected clock ignored", core_in, 16'h0000);
        clk1 = 1'b1;
        #1 chk("R10 selected clock captures", core_in, 16'hFFFF);
        clk1 = 1'b0;

        // R3 on ioclk[1]
        set_all(1'b1, 1'b0, MODE_LATCH);
        ext = 16'h1234;
        #1 chk("R3 sel1 hold while low", core_in, 16'hFFFF);
        clk1 = 1'b1;
        #1 chk("R3 sel1 open", core_in, 16'h1234);
        ext = 16'h4321;
        #1 chk("R3 sel1 follows", core_in, 16'h4321);
        clk1 = 1'b0;
        #1 ext = 16'h0000;
        #1 chk("R3 sel1 closed", core_in, 16'h4321);

        // R9: asynchronous clear without a clock edge
        @(negedge clk0);
        #1 rst = 1'b1;
        #1 chk("R9 async latch clear", core_in, 16'h0000);
        set_all(1'b1, 1'b0, MODE_REG);
        #1 chk("R9 async reg clear", core_in, 16'h0000);
        @(negedge clk0);
        rst = 1'b0;

        // R4 R5: mixed personalities across cells
        for (int i = 0; i < N; i++) begin
            if (i < 4)       mix[i*5 +: 5] = {1'b0, 1'b0, MODE_OUT};
            else if (i < 8)  mix[i*5 +: 5] = {1'b0, 1'b0, MODE_BIDIR};
            else if (i < 12) mix[i*5 +: 5] = {1'b0, 1'b1, MODE_COMB};
            else             mix[i*5 +: 5] = {1'b0, 1'b1, 3'b110};
        end
        #1;
        cell_cfg = mix;
        core_out = 16'hFFFF;
        ext      = 16'h0000;
        bank_oe  = 1'b0;
        #1;
        chk("R4 mixed enable oe low", pad_en, 16'h000F);
        chk("R4 mixed pad value oe low", pad_o, 16'h000F);
        chk("R5 mixed fabric oe low", core_in, 16'h000F);
        bank_oe = 1'b1;
        #1;
        chk("R5 mixed enable oe high", pad_en, 16'h00FF);
        chk("R5 mixed pad value oe high", pad_o, 16'h00FF);
        chk("R5 mixed fabric oe high", core_in, 16'h00FF);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule